// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes stereo PCM audio from a three-wire serial port: a bit clock, a frame clock that separates the left and right half frames, and a data line. All three lines are brought into a fast system clock domain through two-stage synchronizers. The block captures data on each rising bit-clock edge it detects there. A 3-bit format input selects one of five framings. Three are right-aligned, at 16, 20 and 24 bits. The other two are 24-bit left-aligned and 24-bit I2S.

Each completed frame produces a signed 24-bit left/right pair together with a one-cycle valid pulse. Words shorter than 24 bits are placed in the upper bits, and the low bits are zero. For the right-aligned framings, the word position is found by counting back from the frame-clock edge that closes each half frame. A shift register holds the most recent bits, so the block works for any half-frame length of at least the word width. The bit clock must run no faster than half the system clock rate.

Top module: `audio_rx_multi`

## Requirements
- R1: With format code 2 (24-bit left-aligned), the left word is the half frame with the frame clock high, and its MSB is the first bit sampled after the frame-clock edge. A 16-bit or 20-bit word with zero-filled low bits is received unchanged.
- R2: With format code 3 (I2S), the left word is the half frame with the frame clock low, and its MSB is the second bit sampled after the frame-clock edge.
- R3: With format code 0, the last 16 bits of each half frame (frame clock high for left) form the word, which is delivered in bits 23:8 with bits 7:0 zero. This holds for both 16 and 32 bit clocks per half frame.
- R4: With format code 1, the last 20 bits of each half frame form the word, which is delivered in bits 23:4 with bits 3:0 zero.
- R5: With format code 4, the last 24 bits of each half frame form the word. This holds for both 24 and 32 bit clocks per half frame.
- R6: Bit slots outside the word have no effect on the delivered values. These are the slots before the word in right-aligned framings and the slots after bit 24 in the left-aligned and I2S framings.
- R7: Exactly one single-cycle valid pulse follows each completed right half frame, with the left and right outputs updated together. The outputs hold their values between pulses.
- R8: After reset, valid and both outputs are zero. No valid pulse appears until one full left half frame and one full right half frame have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 3 | Framing select (0: RJ16, 1: RJ20, 2: LJ24, 3: I2S, 4: RJ24) |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Frame (left/right) clock, asynchronous |
| sd_i | input | 1 | Serial data, MSB first, two's complement |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The hardest situation to reach is the first partial half frame after reset. If it were wrongly accepted, it would pair a truncated word with a real one. Every stimulus sequence therefore starts mid-stream with a priming frame, and the bench then requires exactly one valid pulse for the single test frame that follows. Slots outside the word are driven as ones in every framing, so a capture window that is off by one slot shows up in the delivered value. A directed case also stops the stream after a right half frame whose closing edge has not yet come, and checks that no pulse appears until that edge arrives.

// File: rtl/audio_rx_multi.sv
module audio_rx_multi (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fmt,
  input  logic        sck_i,
  input  logic        ws_i,
  input  logic        sd_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  localparam int W = 24;
  localparam int CW = 7;

  logic [2:0] sck_q;
  logic [1:0] ws_q, sd_q;
  logic seen, ws_prev, started, have_left;
  logic [CW-1:0] cnt;
  logic [W-1:0] sh, cap, hold_l;

  always_ff @(posedge clk) begin
    sck_q <= {sck_q[1:0], sck_i};
    ws_q  <= {ws_q[0], ws_i};
    sd_q  <= {sd_q[0], sd_i};
  end

  wire rise     = sck_q[1] & ~sck_q[2];
  wire ws_s     = ws_q[1];
  wire sd_s     = sd_q[1];
  wire boundary = rise & seen & (ws_s != ws_prev);
  wire i2s      = (fmt == 3'd3);
  wire done_left = i2s ? ~ws_prev : ws_prev;

  wire [CW-1:0] slot = boundary ? '0 : cnt;
  wire [CW-1:0] pos  = slot - {{(CW-1){1'b0}}, i2s};
  wire          wr   = (pos < CW'(W));
  wire [4:0]    idx  = 5'(W - 1) - pos[4:0];

  logic [W-1:0] word;
  always_comb begin
    case (fmt)
      3'd0:    word = {sh[15:0], 8'b0};
      3'd1:    word = {sh[19:0], 4'b0};
      3'd4:    word = sh;
      default: word = cap;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; ws_prev <= 1'b0; started <= 1'b0; have_left <= 1'b0;
      cnt <= '0; sh <= '0; cap <= '0; hold_l <= '0;
      left_o <= '0; right_o <= '0; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise) begin
        seen    <= 1'b1;
        ws_prev <= ws_s;
        sh      <= {sh[W-2:0], sd_s};
        cnt     <= (slot == '1) ? slot : slot + 1'b1;
        if (wr) cap[idx] <= sd_s;
        if (boundary) begin
          started <= 1'b1;
          if (started) begin
            if (done_left) begin
              hold_l    <= word;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_o    <= hold_l;
              right_o   <= word;
              valid_o   <= 1'b1;
              have_left <= 1'b0;
            end
          end
        end
      end
    end
  end

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  p_pulse_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rise));
  p_rj16_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fmt == 3'd0) |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0));
  p_rj20_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fmt == 3'd1) |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0));
endmodule

// File: tb/tb_audio_rx_multi.sv
module tb_audio_rx_multi;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fmt = 3'd2;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o;
  int checks = 0, fails = 0, nval = 0;
  logic [23:0] gl = '0, gr = '0;

  always #5 clk = ~clk;

  audio_rx_multi dut (.clk(clk), .rst_n(rst_n), .fmt(fmt), .sck_i(sck), .ws_i(ws),
                      .sd_i(sd), .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

  always @(negedge clk) if (valid_o) begin nval++; gl = left_o; gr = right_o; end

  localparam int NV = 8;
  localparam logic [2:0] VF [NV] = '{3'd2, 3'd2, 3'd3, 3'd0, 3'd0, 3'd1, 3'd4, 3'd4};
  localparam int VH [NV] = '{32, 32, 32, 16, 32, 32, 32, 24};
  localparam logic [23:0] VL [NV] = '{24'h123456, 24'hABCD00, 24'h800001, 24'h800100,
                                     24'h123400, 24'hABCDE0, 24'hC0FFEE, 24'h5A5A5A};
  localparam logic [23:0] VR [NV] = '{24'hFEDCBA, 24'h7F0000, 24'h13579B, 24'h7FFE00,
                                     24'hFFFF00, 24'h000010, 24'h000001, 24'hA5A5A5};

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R1";
      3'd3: return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic bit_at(input logic [2:0] f, input int h, input int k,
                                  input logic [23:0] v);
    int n;
    n = (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
    if (f == 3'd2) return (k < 24) ? v[23-k] : 1'b1;
    if (f == 3'd3) return (k >= 1 && k <= 24) ? v[24-k] : 1'b1;
    return (k >= h - n) ? v[23-(k-(h-n))] : 1'b1;
  endfunction

  task automatic half(input logic [2:0] f, input int h, input logic lvl, input logic [23:0] v);
    for (int k = 0; k < h; k++) begin
      @(negedge clk);
      sck = 1'b0; ws = lvl; sd = bit_at(f, h, k, v);
      repeat (2) @(negedge clk);
      sck = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic start(input logic [2:0] f);
    logic ll;
    ll = (f == 3'd3) ? 1'b0 : 1'b1;
    @(negedge clk);
    rst_n = 1'b0; fmt = f; sck = 1'b0; ws = ll; sd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    nval = 0;
  endtask

  task automatic run(input logic [2:0] f, input int h, input logic [23:0] l,
                     input logic [23:0] r, input string tag);
    logic ll;
    ll = (f == 3'd3) ? 1'b0 : 1'b1;
    start(f);
    half(f, h, ll, 24'h0F0F0F);
    half(f, h, ~ll, 24'hF0F0F0);
    half(f, h, ll, l);
    half(f, h, ~ll, r);
    half(f, h, ll, 24'h000000);
    repeat (8) @(negedge clk);
    checks++;
    if (nval != 1) begin
      fails++;
      $display("FAIL R7/R8 (%s): got %0d valid pulses expected 1", tag, nval);
    end
    check(tag, gl, l);
    check(tag, gr, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    start(3'd2);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 reset valid", {23'd0, valid_o}, 24'd0);
    check("R8 reset left", left_o, 24'd0);
    check("R8 reset right", right_o, 24'd0);

    for (int i = 0; i < NV; i++) run(VF[i], VH[i], VL[i], VR[i], tag_of(VF[i]));

    // R6: every non-word slot is one, word is zero
    run(3'd0, 32, 24'h000000, 24'h000000, "R6");
    run(3'd2, 32, 24'h000000, 24'h000000, "R6");
    run(3'd3, 32, 24'h000000, 24'h000000, "R6");

    // R7/R8: right half not yet closed, so no pulse
    start(3'd2);
    half(3'd2, 32, 1'b1, 24'h111111);
    half(3'd2, 32, 1'b0, 24'h222222);
    half(3'd2, 32, 1'b1, 24'h654321);
    half(3'd2, 32, 1'b0, 24'h876543);
    repeat (8) @(negedge clk);
    check("R8 no pulse before close", 24'(nval), 24'd0);
    half(3'd2, 4, 1'b1, 24'h000000);
    repeat (8) @(negedge clk);
    check("R7 pulse count", 24'(nval), 24'd1);
    check("R7 left", gl, 24'h654321);
    check("R7 right", gr, 24'h876543);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule